// File: doc/BRIEF.md
# Configuration Request Descriptor Engine

This block turns a configuration-space request prepared by software in a small register file into one access on a simple configuration port. Software first loads a header word, a byte-enable word, a target word and a write-data word. Each of the last three can be written at its own address or pushed through a three-slot push register. Software then fires the request. The engine decodes the request type and remaps its own bus number to bus 0. For writes it compacts sparse byte enables into a contiguous write. It then drives one request on a valid/ready port. The response arrives in the cycle after the handshake, and the engine records read data and completion status.

Register map (word addresses on `reg_addr`): 0 control, 1 header, 2 byte-enable word, 3 target word, 4 write data, 5 push, 6 status/trigger, 7 idle clear, 8 events, 9 push-mode trigger, 10 read data. Reading an address that holds no register returns 0.

Top module: `cfg_desc_engine`

## Requirements
- R1: The request type comes from header bits [31:24]. The values 0x04 and 0x05 are configuration reads and 0x44 and 0x45 are configuration writes. Any other type makes no port access, but the request still completes.
- R2: Target word bits [31:24] give the bus and bits [23:16] give the devfn. The port offset is target bits [11:2] with the two low bits zero, plus the lane adjustment of R7.
- R3: A requested bus equal to the parameter OWN_BUS (default 0x80) is issued as bus 0.
- R4: When the port answers with present low, the read-data register (address 10) becomes 0xFFFFFFFF. This applies to reads and writes alike.
- R5: A read is issued with length 4 and a dword-aligned offset. When the device is present, the returned word is stored in the read-data register.
- R6: Byte enables (byte-enable word bits [3:0]) of 0xF give a 4-byte write with the data unchanged. Byte enables of 0 make no access and set event bit 3.
- R7: For any other byte-enable pattern, the write length is the number of set bits. The enabled lanes are packed in ascending order into the low bytes. The offset is increased by the index of the lowest enabled lane.
- R8: Writing bit 0 of address 6 fires a request. Status bit 0 reads 1 while the request is in flight. A completed request fired this way sets status bit 25, status bit 31 and event bit 0. Writing 1 to bit 0 of address 7 clears status bit 31. Writing 1 to event bit 0 clears both event bit 0 and status bit 25.
- R9: Writes to address 5 fill the byte-enable word, then the target word, then the write data, and the slot index wraps after three writes. Writing bit 0 of address 9 fires a request and resets the index to 0. Completion of such a request sets event bits 1 and 2 and leaves event bit 0 alone. All event bits clear by writing 1 to them.
- R10: Writing 1 to bit 0 of address 0 loads 0xFFFFFFFF into the read-data register.
- R11: A fire while a request is in flight is ignored. The port holds valid and all request fields steady until ready is high, and it makes exactly one access per accepted fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration port ready |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus after remap |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_offset | output | 12 | Byte offset of first accessed byte |
| cfg_req_len | output | 3 | Access length in bytes (1 to 4) |
| cfg_req_wdata | output | 32 | Packed write data |
| cfg_rsp_present | input | 1 | Target device exists (cycle after handshake) |
| cfg_rsp_rdata | input | 32 | Read data (cycle after handshake) |

## Verification
The bench builds the engine with the default OWN_BUS of 0x80 and with a port model that has three devices, each holding a 64-byte space. This small configuration makes it practical to sweep every one of the sixteen byte-enable patterns over four dword offsets. Each write is read back and compared with a shadow space that the bench updates with its own packing arithmetic. Keeping OWN_BUS nonzero lets the bench observe the remap of the engine's own bus next to an untouched neighbour bus. The model's ready input is throttled, so the bench also covers held requests and fires that arrive while busy.

// File: rtl/cde_pkg.sv
`timescale 1ns/1ps
package cde_pkg;
  localparam int REG_AW = 4;
  localparam int WORD_W = 32;

  localparam logic [REG_AW-1:0] A_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] A_D0      = 4'd1;
  localparam logic [REG_AW-1:0] A_D1      = 4'd2;
  localparam logic [REG_AW-1:0] A_D2      = 4'd3;
  localparam logic [REG_AW-1:0] A_WDAT    = 4'd4;
  localparam logic [REG_AW-1:0] A_PUSH    = 4'd5;
  localparam logic [REG_AW-1:0] A_STAT    = 4'd6;
  localparam logic [REG_AW-1:0] A_IDLECLR = 4'd7;
  localparam logic [REG_AW-1:0] A_EVENT   = 4'd8;
  localparam logic [REG_AW-1:0] A_PFIRE   = 4'd9;
  localparam logic [REG_AW-1:0] A_RDATA   = 4'd10;

  localparam logic [7:0] TY_RD0 = 8'h04;
  localparam logic [7:0] TY_RD1 = 8'h05;
  localparam logic [7:0] TY_WR0 = 8'h44;
  localparam logic [7:0] TY_WR1 = 8'h45;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} seq_state_e;

  typedef struct packed {
    logic              access;
    logic              write;
    logic              be_err;
    logic [7:0]        bus;
    logic [7:0]        devfn;
    logic [11:0]       offset;
    logic [2:0]        len;
    logic [WORD_W-1:0] wdata;
  } cfg_req_t;

  function automatic logic [2:0] lane_count(input logic [3:0] be);
    logic [2:0] c;
    c = 3'd0;
    for (int i = 0; i < 4; i++) c = c + {2'b00, be[i]};
    return c;
  endfunction

  function automatic logic [1:0] low_lane(input logic [3:0] be);
    logic [1:0] f;
    f = 2'd0;
    for (int i = 3; i >= 0; i--) if (be[i]) f = 2'(i);
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_lanes(input logic [3:0] be,
                                                   input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        r[k*8 +: 8] = d[i*8 +: 8];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cde_xlate.sv
`timescale 1ns/1ps
module cde_xlate
  import cde_pkg::*;
#(
  parameter logic [7:0] OWN_BUS = 8'h80
) (
  input  logic [WORD_W-1:0] desc0_i,
  input  logic [WORD_W-1:0] desc1_i,
  input  logic [WORD_W-1:0] desc2_i,
  input  logic [WORD_W-1:0] wdata_i,
  output cfg_req_t          req_o
);
  logic [7:0] ty;
  logic [3:0] be;
  logic       is_rd;
  logic       is_wr;

  always_comb begin
    ty    = desc0_i[31:24];
    be    = desc1_i[3:0];
    is_rd = (ty == TY_RD0) || (ty == TY_RD1);
    is_wr = (ty == TY_WR0) || (ty == TY_WR1);

    req_o        = '0;
    req_o.bus    = (desc2_i[31:24] == OWN_BUS) ? 8'h00 : desc2_i[31:24];
    req_o.devfn  = desc2_i[23:16];
    req_o.offset = {desc2_i[11:2], 2'b00};
    req_o.len    = 3'd4;
    req_o.wdata  = wdata_i;

    if (is_rd) begin
      req_o.access = 1'b1;
    end else if (is_wr) begin
      req_o.write = 1'b1;
      if (be == 4'h0) begin
        req_o.be_err = 1'b1;
      end else if (be == 4'hF) begin
        req_o.access = 1'b1;
      end else begin
        req_o.access = 1'b1;
        req_o.len    = lane_count(be);
        req_o.offset = {desc2_i[11:2], low_lane(be)};
        req_o.wdata  = pack_lanes(be, wdata_i);
      end
    end
  end
endmodule

// File: rtl/cde_regs.sv
`timescale 1ns/1ps
module cde_regs
  import cde_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              fin_fifo_i,
  input  logic              rd_load_i,
  input  logic [WORD_W-1:0] rd_value_i,
  input  logic              be_err_i,
  output logic [WORD_W-1:0] desc0_o,
  output logic [WORD_W-1:0] desc1_o,
  output logic [WORD_W-1:0] desc2_o,
  output logic [WORD_W-1:0] wdat_o,
  output logic              fire_o,
  output logic              fire_fifo_o
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  logic [WORD_W-1:0] desc0_q, desc0_n;
  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [WORD_W-1:0] slot_n [SLOTS];
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [WORD_W-1:0] rdat_q, rdat_n;
  logic              idle_q, idle_n;
  logic              comp_q, comp_n;
  logic [3:0]        ev_q, ev_n;
  logic              wr_en;

  assign wr_en       = we_i;
  assign fire_o      = wr_en && (addr_i == A_STAT)  && wdata_i[0] && !busy_i;
  assign fire_fifo_o = wr_en && (addr_i == A_PFIRE) && wdata_i[0] && !busy_i;

  always_comb begin
    desc0_n = desc0_q;
    for (int s = 0; s < SLOTS; s++) slot_n[s] = slot_q[s];
    idx_n  = idx_q;
    rdat_n = rdat_q;
    idle_n = idle_q;
    comp_n = comp_q;
    ev_n   = ev_q;

    if (wr_en) begin
      for (int s = 0; s < SLOTS; s++)
        if (addr_i == A_D1 + REG_AW'(s)) slot_n[s] = wdata_i;
      case (addr_i)
        A_CTRL:    if (wdata_i[0]) rdat_n = '1;
        A_D0:      desc0_n = wdata_i;
        A_PUSH: begin
          slot_n[idx_q] = wdata_i;
          idx_n = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
        A_IDLECLR: if (wdata_i[0]) idle_n = 1'b0;
        A_EVENT: begin
          ev_n = ev_q & ~wdata_i[3:0];
          if (wdata_i[0]) comp_n = 1'b0;
        end
        A_PFIRE:   if (fire_fifo_o) idx_n = '0;
        default: ;
      endcase
    end

    if (rd_load_i) rdat_n = rd_value_i;
    if (fin_i) begin
      if (fin_fifo_i) begin
        ev_n[2:1] = 2'b11;
      end else begin
        ev_n[0] = 1'b1;
        comp_n  = 1'b1;
        idle_n  = 1'b1;
      end
    end
    if (be_err_i) ev_n[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc0_q <= '0;
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
      idx_q  <= '0;
      rdat_q <= '0;
      idle_q <= 1'b0;
      comp_q <= 1'b0;
      ev_q   <= '0;
    end else begin
      desc0_q <= desc0_n;
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= slot_n[s];
      idx_q  <= idx_n;
      rdat_q <= rdat_n;
      idle_q <= idle_n;
      comp_q <= comp_n;
      ev_q   <= ev_n;
    end
  end

  assign desc0_o = desc0_q;
  assign desc1_o = slot_q[0];
  assign desc2_o = slot_q[1];
  assign wdat_o  = slot_q[2];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_D0:    rdata_o = desc0_q;
      A_D1:    rdata_o = slot_q[0];
      A_D2:    rdata_o = slot_q[1];
      A_WDAT:  rdata_o = slot_q[2];
      A_STAT:  rdata_o = {idle_q, 5'b0, comp_q, 24'b0, busy_i};
      A_EVENT: rdata_o = {28'b0, ev_q};
      A_RDATA: rdata_o = rdat_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cde_seq.sv
`timescale 1ns/1ps
module cde_seq
  import cde_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              fifo_mode_i,
  input  cfg_req_t          req_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              write_o,
  output logic [7:0]        bus_o,
  output logic [7:0]        devfn_o,
  output logic [11:0]       offset_o,
  output logic [2:0]        len_o,
  output logic [WORD_W-1:0] wdata_o,
  input  logic              rsp_present_i,
  input  logic [WORD_W-1:0] rsp_rdata_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              fin_fifo_o,
  output logic              rd_load_o,
  output logic [WORD_W-1:0] rd_value_o,
  output logic              be_err_o
);
  seq_state_e state_q, state_n;
  cfg_req_t   req_q, req_n;
  logic       fifo_q, fifo_n;

  always_comb begin
    state_n = state_q;
    req_n   = req_q;
    fifo_n  = fifo_q;
    case (state_q)
      ST_IDLE: if (fire_i) begin
        req_n   = req_i;
        fifo_n  = fifo_mode_i;
        state_n = req_i.access ? ST_REQ : ST_RSP;
      end
      ST_REQ:  if (ready_i) state_n = ST_RSP;
      ST_RSP:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      fifo_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
      fifo_q  <= fifo_n;
    end
  end

  assign valid_o    = (state_q == ST_REQ);
  assign write_o    = req_q.write;
  assign bus_o      = req_q.bus;
  assign devfn_o    = req_q.devfn;
  assign offset_o   = req_q.offset;
  assign len_o      = req_q.len;
  assign wdata_o    = req_q.wdata;
  assign busy_o     = (state_q != ST_IDLE);
  assign fin_o      = (state_q == ST_RSP);
  assign fin_fifo_o = fifo_q;
  assign be_err_o   = fin_o && req_q.be_err;
  assign rd_load_o  = fin_o && req_q.access && (!rsp_present_i || !req_q.write);
  assign rd_value_o = rsp_present_i ? rsp_rdata_i : '1;
endmodule

// File: rtl/cfg_desc_engine.sv
`timescale 1ns/1ps
module cfg_desc_engine
  import cde_pkg::*;
#(
  parameter logic [7:0] OWN_BUS = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [7:0]        cfg_req_devfn,
  output logic [11:0]       cfg_req_offset,
  output logic [2:0]        cfg_req_len,
  output logic [WORD_W-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_present,
  input  logic [WORD_W-1:0] cfg_rsp_rdata
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic [WORD_W-1:0] d0, d1, d2, wd, rd_value;
  logic              fire, fire_fifo, busy, fin, fin_fifo, rd_load, be_err;
  cfg_req_t          req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  cde_regs #(.SLOTS(3)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy), .fin_i(fin),
    .fin_fifo_i(fin_fifo), .rd_load_i(rd_load), .rd_value_i(rd_value),
    .be_err_i(be_err), .desc0_o(d0), .desc1_o(d1), .desc2_o(d2), .wdat_o(wd),
    .fire_o(fire), .fire_fifo_o(fire_fifo)
  );

  cde_xlate #(.OWN_BUS(OWN_BUS)) u_xlate (
    .desc0_i(d0), .desc1_i(d1), .desc2_i(d2), .wdata_i(wd), .req_o(req)
  );

  cde_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .fire_i(fire | fire_fifo), .fifo_mode_i(fire_fifo),
    .req_i(req), .valid_o(cfg_req_valid), .ready_i(cfg_req_ready),
    .write_o(cfg_req_write), .bus_o(cfg_req_bus), .devfn_o(cfg_req_devfn),
    .offset_o(cfg_req_offset), .len_o(cfg_req_len), .wdata_o(cfg_req_wdata),
    .rsp_present_i(cfg_rsp_present), .rsp_rdata_i(cfg_rsp_rdata),
    .busy_o(busy), .fin_o(fin), .fin_fifo_o(fin_fifo), .rd_load_o(rd_load),
    .rd_value_o(rd_value), .be_err_o(be_err)
  );
endmodule

// File: rtl/cfg_desc_engine_chk.sv
`timescale 1ns/1ps
module cfg_desc_engine_chk #(
  parameter logic [7:0] OWN_BUS = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        ready,
  input logic        write,
  input logic [7:0]  bus,
  input logic [7:0]  devfn,
  input logic [11:0] offset,
  input logic [2:0]  len,
  input logic [31:0] wdata,
  input logic        rsp_present,
  input logic        rd_load,
  input logic [31:0] rd_value
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable({write, bus, devfn, offset, len, wdata})));

  assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !valid);

  assert_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (OWN_BUS != 8'h00)) |-> (bus != OWN_BUS));

  assert_read_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !write) |-> (len == 3'd4 && offset[1:0] == 2'b00));

  assert_write_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write) |-> (len != 3'd0 && (4'(offset[1:0]) + 4'(len)) <= 4'd4));

  assert_missing_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid && ready) && !rsp_present) |-> (rd_load && rd_value == 32'hFFFF_FFFF));
endmodule

bind cfg_desc_engine cfg_desc_engine_chk #(.OWN_BUS(OWN_BUS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .valid(cfg_req_valid), .ready(cfg_req_ready),
  .write(cfg_req_write), .bus(cfg_req_bus), .devfn(cfg_req_devfn),
  .offset(cfg_req_offset), .len(cfg_req_len), .wdata(cfg_req_wdata),
  .rsp_present(cfg_rsp_present), .rd_load(rd_load), .rd_value(rd_value)
);

// File: tb/cfg_desc_engine_bench.sv
`timescale 1ns/1ps
module cfg_desc_engine_bench;
  import cde_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready;
  logic [7:0]  cfg_req_bus, cfg_req_devfn;
  logic [11:0] cfg_req_offset;
  logic [2:0]  cfg_req_len;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_present;
  logic [31:0] cfg_rsp_rdata;

  int errs = 0;
  int checks = 0;
  logic ready_en = 1'b1;

  always #5 clk = ~clk;

  cfg_desc_engine u_cfg_desc_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_bus(cfg_req_bus),
    .cfg_req_devfn(cfg_req_devfn), .cfg_req_offset(cfg_req_offset),
    .cfg_req_len(cfg_req_len), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_present(cfg_rsp_present), .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  // Port model: three devices with 64 bytes each
  logic [7:0]  mem [3][64];
  logic [7:0]  shd [3][64];
  int          acc_cnt;
  int          tick;
  logic [7:0]  last_bus, last_devfn;
  logic [11:0] last_off;
  logic [2:0]  last_len;

  function automatic int dev_of(input logic [7:0] b, input logic [7:0] df);
    if (b == 8'h00 && df == 8'h00) return 0;
    if (b == 8'h00 && df == 8'h08) return 1;
    if (b == 8'h01 && df == 8'h10) return 2;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 3; d++)
        for (int i = 0; i < 64; i++) mem[d][i] <= 8'((d * 64 + i) ^ 8'h5A);
      cfg_req_ready   <= 1'b0;
      cfg_rsp_present <= 1'b0;
      cfg_rsp_rdata   <= 32'd0;
      acc_cnt <= 0;
      tick    <= 0;
      last_bus <= 8'd0; last_devfn <= 8'd0; last_off <= 12'd0; last_len <= 3'd0;
    end else begin
      tick <= tick + 1;
      cfg_req_ready   <= ready_en && (tick % 3 != 2);
      cfg_rsp_present <= 1'b0;
      cfg_rsp_rdata   <= 32'hDEAD_BEEF;
      if (cfg_req_valid && cfg_req_ready) begin
        int dv;
        int o;
        dv = dev_of(cfg_req_bus, cfg_req_devfn);
        o  = int'(cfg_req_offset[5:0]);
        acc_cnt    <= acc_cnt + 1;
        last_bus   <= cfg_req_bus;
        last_devfn <= cfg_req_devfn;
        last_off   <= cfg_req_offset;
        last_len   <= cfg_req_len;
        if (dv >= 0) begin
          cfg_rsp_present <= 1'b1;
          if (cfg_req_write) begin
            for (int k = 0; k < 4; k++)
              if (k < int'(cfg_req_len)) mem[dv][o + k] <= cfg_req_wdata[k*8 +: 8];
          end else begin
            cfg_rsp_rdata <= {mem[dv][o+3], mem[dv][o+2], mem[dv][o+1], mem[dv][o]};
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(A_STAT, v);
      if (!v[0]) break;
    end
  endtask

  task automatic issue(input logic [31:0] d0, input logic [31:0] d1,
                       input logic [31:0] d2, input logic [31:0] wd);
    wr(A_D0, d0); wr(A_D1, d1); wr(A_D2, d2); wr(A_WDAT, wd);
    wr(A_STAT, 32'd1);
    wait_idle();
  endtask

  function automatic logic [31:0] shd_word(input int d, input int off);
    return {shd[d][off+3], shd[d][off+2], shd[d][off+1], shd[d][off]};
  endfunction

  task automatic shd_write(input int d, input int off, input logic [3:0] be,
                           input logic [31:0] data);
    int k;
    int first;
    if (be == 4'h0) return;
    if (be == 4'hF) begin
      for (int i = 0; i < 4; i++) shd[d][off + i] = data[i*8 +: 8];
      return;
    end
    first = -1;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        if (first < 0) first = i;
        shd[d][off + first + k] = data[i*8 +: 8];
        k++;
      end
    end
  endtask

  initial begin
    #1ms;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt0;
    for (int d = 0; d < 3; d++)
      for (int i = 0; i < 64; i++) shd[d][i] = 8'((d * 64 + i) ^ 8'h5A);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    rd(A_STAT, v);  check("R8 reset status", v, 32'd0);
    rd(A_EVENT, v); check("R9 reset events", v, 32'd0);
    rd(A_RDATA, v); check("R5 reset rdata", v, 32'd0);

    // R3/R2: own bus remapped to bus 0, read dev1 offset 0x10
    issue(32'h0400_0000, 32'h0, {8'h80, 8'h08, 4'h0, 12'h010}, 32'h0);
    rd(A_RDATA, v); check("R3 remapped read data", v, shd_word(1, 16));
    check("R3 port bus", {24'd0, last_bus}, 32'd0);
    check("R2 port devfn", {24'd0, last_devfn}, 32'h08);
    check("R5 read length", {29'd0, last_len}, 32'd4);

    // R8: completion status and clears
    rd(A_STAT, v);  check("R8 status after direct fire", v, 32'h8200_0000);
    rd(A_EVENT, v); check("R8 done event", v & 32'h1, 32'h1);
    wr(A_IDLECLR, 32'd1);
    rd(A_STAT, v);  check("R8 idle cleared", v, 32'h0200_0000);
    wr(A_EVENT, 32'd1);
    rd(A_STAT, v);  check("R8 complete cleared", v, 32'h0);
    rd(A_EVENT, v); check("R8 done cleared", v, 32'h0);

    // R1: type 1 read to bus 1 devfn 0x10
    issue(32'h0500_0000, 32'h0, {8'h01, 8'h10, 4'h0, 12'h020}, 32'h0);
    rd(A_RDATA, v); check("R1 type1 read", v, shd_word(2, 32));

    // R1/R6: type 1 write, full enables
    issue(32'h4500_0000, 32'hF, {8'h01, 8'h10, 4'h0, 12'h024}, 32'hCAFE_F00D);
    shd_write(2, 36, 4'hF, 32'hCAFE_F00D);
    issue(32'h0400_0000, 32'h0, {8'h01, 8'h10, 4'h0, 12'h024}, 32'h0);
    rd(A_RDATA, v); check("R6 full write readback", v, 32'hCAFE_F00D);

    // R4: missing device on neighbour bus, read and write
    issue(32'h0400_0000, 32'h0, {8'h81, 8'h00, 4'h0, 12'h000}, 32'h0);
    rd(A_RDATA, v); check("R4 missing read", v, 32'hFFFF_FFFF);
    check("R3 neighbour bus kept", {24'd0, last_bus}, 32'h81);
    issue(32'h0400_0000, 32'h0, {8'h00, 8'h00, 4'h0, 12'h000}, 32'h0);
    issue(32'h4400_0000, 32'hF, {8'h02, 8'h00, 4'h0, 12'h000}, 32'h1234_5678);
    rd(A_RDATA, v); check("R4 missing write", v, 32'hFFFF_FFFF);

    // R1: unknown type, no access, completion still flagged
    issue(32'h0400_0000, 32'h0, {8'h00, 8'h00, 4'h0, 12'h004}, 32'h0);
    cnt0 = acc_cnt;
    wr(A_EVENT, 32'hF);
    issue(32'h2000_0000, 32'hF, {8'h00, 8'h00, 4'h0, 12'h008}, 32'h0);
    check("R1 unknown no access", acc_cnt, cnt0);
    rd(A_RDATA, v); check("R1 unknown keeps rdata", v, shd_word(0, 4));
    rd(A_EVENT, v); check("R1 unknown completes", v, 32'h1);

    // R10: clear receive
    wr(A_CTRL, 32'd1);
    rd(A_RDATA, v); check("R10 clear receive", v, 32'hFFFF_FFFF);

    // R6/R7: sweep all byte enables over four dwords of dev1
    for (int be = 0; be < 16; be++) begin
      for (int dw = 0; dw < 4; dw++) begin
        logic [31:0] wdv;
        int expl;
        int fl;
        wdv = 32'h8C4A_2E17 ^ {8{4'(be)}} ^ 32'(dw);
        cnt0 = acc_cnt;
        wr(A_EVENT, 32'hF);
        issue(32'h4400_0000, 32'(be), {8'h00, 8'h08, 4'h0, 12'(dw * 4)}, wdv);
        shd_write(1, dw * 4, 4'(be), wdv);
        if (be == 0) begin
          check("R6 zero enables no access", acc_cnt, cnt0);
          rd(A_EVENT, v); check("R6 zero enables flagged", v & 32'h8, 32'h8);
        end else begin
          expl = 0;
          fl = -1;
          for (int i = 0; i < 4; i++) if (be[i]) begin expl++; if (fl < 0) fl = i; end
          check("R7 write length", {29'd0, last_len}, 32'(expl));
          check("R7 write offset", {20'd0, last_off}, 32'(dw * 4 + fl));
        end
        issue(32'h0400_0000, 32'h0, {8'h00, 8'h08, 4'h0, 12'(dw * 4)}, 32'h0);
        rd(A_RDATA, v); check("R7 packed write readback", v, shd_word(1, dw * 4));
      end
    end

    // R9: push order, wrap, index reset on fire, event bits
    wr(A_EVENT, 32'hF);
    wr(A_PUSH, 32'hAAAA_0001); wr(A_PUSH, 32'hBBBB_0002);
    wr(A_PUSH, 32'hCCCC_0003); wr(A_PUSH, 32'hDDDD_0004);
    rd(A_D1, v);   check("R9 wrap to first slot", v, 32'hDDDD_0004);
    rd(A_D2, v);   check("R9 second slot", v, 32'hBBBB_0002);
    rd(A_WDAT, v); check("R9 third slot", v, 32'hCCCC_0003);
    wr(A_D0, 32'h4400_0000);
    wr(A_PFIRE, 32'd1);
    wait_idle();
    wr(A_PUSH, 32'h0000_0003);
    wr(A_PUSH, {8'h00, 8'h00, 4'h0, 12'h030});
    wr(A_PUSH, 32'h0000_9A7B);
    wr(A_PFIRE, 32'd1);
    wait_idle();
    shd_write(0, 48, 4'h3, 32'h0000_9A7B);
    rd(A_EVENT, v); check("R9 fifo events set", v & 32'h7, 32'h6);
    wr(A_EVENT, 32'h2);
    rd(A_EVENT, v); check("R9 tx-idle event cleared alone", v & 32'h7, 32'h4);
    issue(32'h0400_0000, 32'h0, {8'h00, 8'h00, 4'h0, 12'h030}, 32'h0);
    rd(A_RDATA, v); check("R9 fifo write readback", v, shd_word(0, 48));

    // R11: fire while busy is ignored
    ready_en = 1'b0;
    repeat (2) @(negedge clk);
    cnt0 = acc_cnt;
    wr(A_D0, 32'h0400_0000); wr(A_D2, {8'h00, 8'h08, 4'h0, 12'h000});
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); check("R8 busy while in flight", v & 32'h1, 32'h1);
    check("R11 valid held", {31'd0, cfg_req_valid}, 32'h1);
    wr(A_D2, {8'h00, 8'h08, 4'h0, 12'h030});
    wr(A_STAT, 32'd1);
    ready_en = 1'b1;
    wait_idle();
    repeat (10) @(negedge clk);
    check("R11 single access", acc_cnt, cnt0 + 1);
    check("R11 first request kept", {20'd0, last_off}, 32'h0);
    rd(A_RDATA, v); check("R11 read data of first request", v, shd_word(1, 0));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule